// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Squash Walker

This block keeps the in-flight instructions of up to four hardware threads in program order until they commit. Each thread owns a small circular queue. Every entry holds a global sequence number, a ready-to-commit flag and a squashed flag. Dispatch appends an entry to the tail of the named thread. Completion marks a matching entry ready. Retire removes the head of a thread once that head is ready.

A squash request names a thread and a sequence number. Each entry of that thread that is younger than the number must become squashed. The block does this with a walker that moves from the youngest entry toward the head and marks a bounded number of entries per cycle. A marked entry is also set ready, so it drains through the normal retire path. While the walk runs, the thread takes no dispatch and no retire.

Across the active threads the block reports the oldest head and the youngest tail. It finds them by comparing sequence numbers.

Top module: `mt_rob`

## Requirements
- R1: An accepted dispatch appends the entry at the tail of its thread's queue. The per-thread count and the total count each rise by one in the next cycle.
- R2: A dispatch to a thread whose queue holds DEPTH entries is ignored. The count and the tail stay unchanged, and `disp_ready_o` for that thread is low.
- R3: A retire of a thread whose head is not ready to commit is ignored. A retire of a ready head removes that head, and both counts fall by one.
- R4: `head_rdy_o[t]` is 1 only when thread t holds entries and its head entry is ready. A completion (tid, seq) sets ready only on the entry of that thread whose sequence number matches.
- R5: `commit_ok_o` is 1 exactly when some thread that is set in `active_i` has a ready head.
- R6: A squash request to a thread with no entries does nothing, and `sq_busy_o` for that thread stays 0.
- R7: A walk starts at the thread's youngest entry and moves toward the head. In each cycle after the request cycle it marks at most SQ_W entries, and each marked entry becomes both squashed and ready. With SQ_W = 2, four squashed entries plus a stop give 3 busy cycles, and eight entries down to the head give 4 busy cycles.
- R8: A walk ends in the cycle it reaches an entry whose sequence number is at or below the squash number, or after it marks the head entry. Older entries keep their squashed flag at 0, and `sq_busy_o` falls.
- R9: While `sq_busy_o[t]` is 1, dispatch to thread t and retire of thread t are both ignored, and `disp_ready_o[t]` is 0.
- R10: `ghead_*` gives the head with the lowest sequence number among the active threads that hold entries. It is invalid when there is no such thread.
- R11: `gtail_*` gives the tail with the highest sequence number among the active threads that hold entries. It is invalid when there is no such thread.
- R12: After reset every queue is empty, no walk is running, and all valid, ready and busy outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_i | input | NUM_THR | Threads taking part in global selection and commit-possible |
| disp_valid_i | input | 1 | Dispatch request |
| disp_tid_i | input | TID_W | Dispatch thread |
| disp_seq_i | input | SEQ_W | Dispatch sequence number |
| cpl_valid_i | input | 1 | Completion request |
| cpl_tid_i | input | TID_W | Completion thread |
| cpl_seq_i | input | SEQ_W | Sequence number of the completed entry |
| retire_i | input | NUM_THR | Per-thread retire-head request |
| sq_valid_i | input | 1 | Squash request |
| sq_tid_i | input | TID_W | Squash thread |
| sq_seq_i | input | SEQ_W | Squash number; entries above it are squashed |
| disp_ready_o | output | NUM_THR | Thread can take a dispatch (not full, not walking) |
| thr_cnt_o | output | NUM_THR*CNT_W | Per-thread entry counts, thread t at bits [t*CNT_W +: CNT_W] |
| tot_cnt_o | output | TOT_W | Total entry count |
| head_rdy_o | output | NUM_THR | Thread head is ready to commit |
| head_sqd_o | output | NUM_THR | Thread head is squashed |
| commit_ok_o | output | 1 | Some active thread has a ready head |
| ghead_valid_o | output | 1 | Global oldest head valid |
| ghead_tid_o | output | TID_W | Thread of the global oldest head |
| ghead_seq_o | output | SEQ_W | Sequence number of the global oldest head |
| gtail_valid_o | output | 1 | Global youngest tail valid |
| gtail_tid_o | output | TID_W | Thread of the global youngest tail |
| gtail_seq_o | output | SEQ_W | Sequence number of the global youngest tail |
| sq_busy_o | output | NUM_THR | Squash walk in progress per thread |

## Verification
The assertions assume that sequence numbers rise with every dispatch and never wrap. They also assume that a completion names a number that is unique within its thread. The age checks on the global head and tail are valid only under these conditions. The stimulus dispatches strictly increasing numbers, gives each thread its own range, and issues a new squash only after `sq_busy_o` has fallen. Dispatch and retire are driven during a walk on purpose, to show that the thread ignores them.

// File: rtl/mt_rob_pkg.sv
package mt_rob_pkg;
  localparam int THR_DEF   = 4;
  localparam int DEPTH_DEF = 8;
  localparam int SEQ_W_DEF = 16;
  localparam int SQ_W_DEF  = 2;

  typedef enum logic {PICK_OLDEST = 1'b0, PICK_YOUNGEST = 1'b1} pick_e;
endpackage

// File: rtl/mt_rob_thread_q.sv
module mt_rob_thread_q #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int SQ_W  = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [SEQ_W-1:0] push_seq_i,
  input  logic             cpl_i,
  input  logic [SEQ_W-1:0] cpl_seq_i,
  input  logic             pop_i,
  input  logic             sq_req_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             push_rdy_o,
  output logic [SEQ_W-1:0] head_seq_o,
  output logic             head_rdy_o,
  output logic             head_sqd_o,
  output logic [SEQ_W-1:0] tail_seq_o,
  output logic             busy_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] SQ_LIM  = CNT_W'(SQ_W);

  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [DEPTH-1:0] vld_q, rdy_q, sqd_q;
  logic [PTR_W-1:0] hd_q, tl_q, tl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // walker state
  logic             busy_q;
  logic [PTR_W-1:0] wp_q;
  logic [CNT_W-1:0] wleft_q;
  logic [SEQ_W-1:0] wnum_q;
  logic [DEPTH-1:0] mark;
  logic [CNT_W-1:0] nmark;
  logic             wdone;

  logic push_ok, pop_ok;

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == DEPTH_C);
  assign push_rdy_o = !full_o && !busy_q;
  assign push_ok    = push_i && push_rdy_o;
  assign pop_ok     = pop_i && !empty_o && rdy_q[hd_q] && !busy_q;
  assign cnt_d      = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
  assign tl_d       = tl_q + PTR_W'(push_ok);

  always_comb begin
    logic             alive;
    logic [PTR_W-1:0] idx;
    mark  = '0;
    nmark = '0;
    alive = busy_q;
    for (int j = 0; j < SQ_W; j++) begin
      idx = wp_q - PTR_W'(j);
      if (alive && (CNT_W'(j) < wleft_q) && (seq_q[idx] > wnum_q)) begin
        mark[idx] = 1'b1;
        nmark     = nmark + 1'b1;
      end else begin
        alive = 1'b0;
      end
    end
    // stop on an old entry, or when the head has been marked
    wdone = busy_q && ((nmark < SQ_LIM) || (nmark == wleft_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) seq_q[i] <= '0;
      vld_q   <= '0;
      rdy_q   <= '0;
      sqd_q   <= '0;
      hd_q    <= '0;
      tl_q    <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      wp_q    <= '0;
      wleft_q <= '0;
      wnum_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cpl_i && vld_q[i] && (seq_q[i] == cpl_seq_i)) rdy_q[i] <= 1'b1;
        if (mark[i]) begin
          rdy_q[i] <= 1'b1;
          sqd_q[i] <= 1'b1;
        end
      end
      if (push_ok) begin
        seq_q[tl_q] <= push_seq_i;
        vld_q[tl_q] <= 1'b1;
        rdy_q[tl_q] <= 1'b0;
        sqd_q[tl_q] <= 1'b0;
      end
      if (pop_ok) begin
        vld_q[hd_q] <= 1'b0;
        hd_q        <= hd_q + PTR_W'(1);
      end
      tl_q  <= tl_d;
      cnt_q <= cnt_d;

      if (busy_q) begin
        if (wdone) busy_q <= 1'b0;
        else begin
          wp_q    <= wp_q - PTR_W'(nmark);
          wleft_q <= wleft_q - nmark;
        end
      end else if (sq_req_i && (cnt_d != '0)) begin
        busy_q  <= 1'b1;
        wp_q    <= tl_d - PTR_W'(1);
        wleft_q <= cnt_d;
        wnum_q  <= sq_seq_i;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign head_seq_o = seq_q[hd_q];
  assign head_rdy_o = !empty_o && rdy_q[hd_q];
  assign head_sqd_o = !empty_o && sqd_q[hd_q];
  assign tail_seq_o = seq_q[tl_q - PTR_W'(1)];
  assign busy_o     = busy_q;

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q)); // R2
  AST_RETIRE_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !head_rdy_o && !push_i) |=> $stable(cnt_q)); // R3
  AST_EMPTY_NO_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && sq_req_i && empty_o && !push_i) |=> !busy_q); // R6
  AST_WALK_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> ($countones(sqd_q ^ $past(sqd_q)) <= SQ_W)); // R7
  AST_WALK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/mt_rob_age_pick.sv
module mt_rob_age_pick
  import mt_rob_pkg::*;
#(
  parameter int    N     = 4,
  parameter int    SEQ_W = 16,
  parameter pick_e MODE  = PICK_OLDEST,
  parameter int    IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       valid_i,
  input  logic [N*SEQ_W-1:0] seq_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [SEQ_W-1:0]   seq_o
);
  always_comb begin
    logic [SEQ_W-1:0] cur;
    logic             better;
    valid_o = 1'b0;
    idx_o   = '0;
    seq_o   = '0;
    for (int i = 0; i < N; i++) begin
      cur    = seq_i[i*SEQ_W +: SEQ_W];
      better = (MODE == PICK_OLDEST) ? (cur < seq_o) : (cur > seq_o);
      if (valid_i[i] && (!valid_o || better)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        seq_o   = cur;
      end
    end
  end
endmodule

// File: rtl/mt_rob.sv
module mt_rob
  import mt_rob_pkg::*;
#(
  parameter int NUM_THR = THR_DEF,
  parameter int DEPTH   = DEPTH_DEF,
  parameter int SEQ_W   = SEQ_W_DEF,
  parameter int SQ_W    = SQ_W_DEF,
  parameter int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  parameter int CNT_W   = $clog2(DEPTH + 1),
  parameter int TOT_W   = $clog2(NUM_THR * DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_THR-1:0]       active_i,
  input  logic                     disp_valid_i,
  input  logic [TID_W-1:0]         disp_tid_i,
  input  logic [SEQ_W-1:0]         disp_seq_i,
  input  logic                     cpl_valid_i,
  input  logic [TID_W-1:0]         cpl_tid_i,
  input  logic [SEQ_W-1:0]         cpl_seq_i,
  input  logic [NUM_THR-1:0]       retire_i,
  input  logic                     sq_valid_i,
  input  logic [TID_W-1:0]         sq_tid_i,
  input  logic [SEQ_W-1:0]         sq_seq_i,
  output logic [NUM_THR-1:0]       disp_ready_o,
  output logic [NUM_THR*CNT_W-1:0] thr_cnt_o,
  output logic [TOT_W-1:0]         tot_cnt_o,
  output logic [NUM_THR-1:0]       head_rdy_o,
  output logic [NUM_THR-1:0]       head_sqd_o,
  output logic                     commit_ok_o,
  output logic                     ghead_valid_o,
  output logic [TID_W-1:0]         ghead_tid_o,
  output logic [SEQ_W-1:0]         ghead_seq_o,
  output logic                     gtail_valid_o,
  output logic [TID_W-1:0]         gtail_tid_o,
  output logic [SEQ_W-1:0]         gtail_seq_o,
  output logic [NUM_THR-1:0]       sq_busy_o
);
  logic [NUM_THR-1:0]       empty, full;
  logic [CNT_W-1:0]         cnt [NUM_THR];
  logic [NUM_THR*SEQ_W-1:0] head_seq, tail_seq;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    mt_rob_thread_q #(
      .DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_W(SQ_W), .CNT_W(CNT_W)
    ) u_q (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (disp_valid_i && (disp_tid_i == TID_W'(t))),
      .push_seq_i (disp_seq_i),
      .cpl_i      (cpl_valid_i && (cpl_tid_i == TID_W'(t))),
      .cpl_seq_i  (cpl_seq_i),
      .pop_i      (retire_i[t]),
      .sq_req_i   (sq_valid_i && (sq_tid_i == TID_W'(t))),
      .sq_seq_i   (sq_seq_i),
      .cnt_o      (cnt[t]),
      .empty_o    (empty[t]),
      .full_o     (full[t]),
      .push_rdy_o (disp_ready_o[t]),
      .head_seq_o (head_seq[t*SEQ_W +: SEQ_W]),
      .head_rdy_o (head_rdy_o[t]),
      .head_sqd_o (head_sqd_o[t]),
      .tail_seq_o (tail_seq[t*SEQ_W +: SEQ_W]),
      .busy_o     (sq_busy_o[t])
    );
    assign thr_cnt_o[t*CNT_W +: CNT_W] = cnt[t];
  end

  always_comb begin
    tot_cnt_o = '0;
    for (int t = 0; t < NUM_THR; t++) tot_cnt_o = tot_cnt_o + TOT_W'(cnt[t]);
  end

  logic [NUM_THR-1:0] live;
  assign live        = active_i & ~empty;
  assign commit_ok_o = |(active_i & head_rdy_o);

  mt_rob_age_pick #(.N(NUM_THR), .SEQ_W(SEQ_W), .MODE(PICK_OLDEST), .IDX_W(TID_W)) u_head_pick (
    .valid_i (live),
    .seq_i   (head_seq),
    .valid_o (ghead_valid_o),
    .idx_o   (ghead_tid_o),
    .seq_o   (ghead_seq_o)
  );

  mt_rob_age_pick #(.N(NUM_THR), .SEQ_W(SEQ_W), .MODE(PICK_YOUNGEST), .IDX_W(TID_W)) u_tail_pick (
    .valid_i (live),
    .seq_i   (tail_seq),
    .valid_o (gtail_valid_o),
    .idx_o   (gtail_tid_o),
    .seq_o   (gtail_seq_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      for (int t = 0; t < NUM_THR; t++) begin
        if (live[t]) begin
          AST_GHEAD_OLDEST: assert (ghead_valid_o && (ghead_seq_o <= head_seq[t*SEQ_W +: SEQ_W])); // R10
          AST_GTAIL_YOUNGEST: assert (gtail_valid_o && (gtail_seq_o >= tail_seq[t*SEQ_W +: SEQ_W])); // R11
        end
      end
    end
  end
endmodule

// File: tb/mt_rob_bench.sv
`timescale 1ns/1ps
module mt_rob_bench;
  localparam int NT = 4, CW = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  active;
  logic        disp_v, cpl_v, sq_v;
  logic [1:0]  disp_t, cpl_t, sq_t;
  logic [15:0] disp_s, cpl_s, sq_s;
  logic [3:0]  retire;
  logic [3:0]  disp_rdy, head_rdy, head_sqd, sq_busy;
  logic [15:0] thr_cnt;
  logic [5:0]  tot_cnt;
  logic        commit_ok, gh_v, gt_v;
  logic [1:0]  gh_t, gt_t;
  logic [15:0] gh_s, gt_s;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mt_rob u_mt_rob (
    .clk_i(clk), .rst_ni(rst_n), .active_i(active),
    .disp_valid_i(disp_v), .disp_tid_i(disp_t), .disp_seq_i(disp_s),
    .cpl_valid_i(cpl_v), .cpl_tid_i(cpl_t), .cpl_seq_i(cpl_s),
    .retire_i(retire), .sq_valid_i(sq_v), .sq_tid_i(sq_t), .sq_seq_i(sq_s),
    .disp_ready_o(disp_rdy), .thr_cnt_o(thr_cnt), .tot_cnt_o(tot_cnt),
    .head_rdy_o(head_rdy), .head_sqd_o(head_sqd), .commit_ok_o(commit_ok),
    .ghead_valid_o(gh_v), .ghead_tid_o(gh_t), .ghead_seq_o(gh_s),
    .gtail_valid_o(gt_v), .gtail_tid_o(gt_t), .gtail_seq_o(gt_s),
    .sq_busy_o(sq_busy)
  );

  function automatic int cnt(input int t);
    return int'(thr_cnt[t*CW +: CW]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_v = 0; cpl_v = 0; sq_v = 0; retire = '0;
    disp_t = '0; cpl_t = '0; sq_t = '0; disp_s = '0; cpl_s = '0; sq_s = '0;
  endtask

  task automatic disp(input int t, input int s);
    disp_v = 1; disp_t = 2'(t); disp_s = 16'(s);
    @(negedge clk); disp_v = 0;
  endtask

  task automatic cpl(input int t, input int s);
    cpl_v = 1; cpl_t = 2'(t); cpl_s = 16'(s);
    @(negedge clk); cpl_v = 0;
  endtask

  task automatic ret(input logic [3:0] m, input int cycles);
    retire = m;
    repeat (cycles) @(negedge clk);
    retire = '0;
  endtask

  task automatic sq_req(input int t, input int s);
    sq_v = 1; sq_t = 2'(t); sq_s = 16'(s);
    @(negedge clk); sq_v = 0;
  endtask

  task automatic t_reset();
    chk("R12 total", tot_cnt, 0);
    chk("R12 ghead valid", gh_v, 0);
    chk("R12 gtail valid", gt_v, 0);
    chk("R12 commit_ok", commit_ok, 0);
    chk("R12 busy", sq_busy, 0);
    chk("R12 head_rdy", head_rdy, 0);
    chk("R12 disp_ready", disp_rdy, 4'hF);
  endtask

  task automatic t_dispatch();
    disp(0, 1); disp(1, 2); disp(0, 3); disp(2, 4);
    chk("R1 total", tot_cnt, 4);
    chk("R1 thr0 count", cnt(0), 2);
    chk("R10 ghead seq", gh_s, 1);
    chk("R10 ghead tid", gh_t, 0);
    chk("R11 gtail seq", gt_s, 4);
    chk("R11 gtail tid", gt_t, 2);
    active = 4'b0001; #1;
    chk("R11 gtail thr0 only", gt_s, 3);
    active = 4'b0010; #1;
    chk("R10 ghead thr1 only", gh_s, 2);
    chk("R10 ghead tid thr1 only", gh_t, 1);
    active = 4'hF; #1;
  endtask

  task automatic t_ready();
    chk("R4 no ready heads", head_rdy, 0);
    cpl(0, 3);
    chk("R4 non-head completion", head_rdy[0], 0);
    chk("R5 no commit", commit_ok, 0);
    cpl(0, 1);
    chk("R4 head ready", head_rdy[0], 1);
    chk("R5 commit ok", commit_ok, 1);
    active = 4'b1110; #1;
    chk("R5 inactive thread masked", commit_ok, 0);
    active = 4'hF; #1;
  endtask

  task automatic t_retire();
    ret(4'b0010, 1);
    chk("R3 unready retire ignored", tot_cnt, 4);
    ret(4'b0001, 1);
    chk("R3 retire total", tot_cnt, 3);
    chk("R10 new oldest seq", gh_s, 2);
    chk("R10 new oldest tid", gh_t, 1);
    chk("R4 next head ready", head_rdy[0], 1);
    ret(4'b0001, 1);
    chk("R3 thr0 drained", cnt(0), 0);
    cpl(1, 2); cpl(2, 4);
    ret(4'b0110, 1);
    chk("R3 all drained", tot_cnt, 0);
    chk("R10 ghead invalid", gh_v, 0);
    chk("R11 gtail invalid", gt_v, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) disp(3, 100 + i);
    chk("R1 thr3 count", cnt(3), 8);
    chk("R2 not ready when full", disp_rdy[3], 0);
    disp(3, 108);
    chk("R2 full dispatch ignored", cnt(3), 8);
    chk("R2 tail unchanged", gt_s, 107);
  endtask

  task automatic t_sq_empty();
    sq_req(1, 0);
    chk("R6 empty thread busy", sq_busy[1], 0);
    @(negedge clk);
    chk("R6 empty thread still idle", sq_busy[1], 0);
    chk("R6 count", cnt(1), 0);
  endtask

  task automatic t_sq_walk();
    int bc;
    for (int i = 0; i < 5; i++) disp(2, 200 + i);
    cpl(2, 200);
    sq_req(2, 200);
    chk("R9 busy raised", sq_busy[2], 1);
    chk("R9 dispatch not ready", disp_rdy[2], 0);
    disp_v = 1; disp_t = 2; disp_s = 205; retire = 4'b0100;
    @(negedge clk);
    disp_v = 0; retire = '0;
    bc = 1;
    while (sq_busy[2] && bc < 20) begin bc++; @(negedge clk); end
    chk("R7 busy cycles partial walk", bc, 3);
    chk("R9 count frozen", cnt(2), 5);
    chk("R8 older head ready", head_rdy[2], 1);
    chk("R8 older head not squashed", head_sqd[2], 0);
    ret(4'b0100, 1);
    chk("R7 younger head squashed", head_sqd[2], 1);
    chk("R7 younger head ready", head_rdy[2], 1);
    ret(4'b0100, 4);
    chk("R7 squashed entries drain", cnt(2), 0);
  endtask

  task automatic t_sq_head();
    int bc;
    sq_req(3, 50);
    bc = 0;
    while (sq_busy[3] && bc < 20) begin bc++; @(negedge clk); end
    chk("R7 busy cycles to head", bc, 4);
    chk("R8 head squashed", head_sqd[3], 1);
    chk("R11 tail kept", gt_s, 107);
    ret(4'b1000, 8);
    chk("R7 all drained", cnt(3), 0);
    chk("R11 gtail invalid", gt_v, 0);
  endtask

  initial begin
    idle();
    active = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dispatch();
    t_ready();
    t_retire();
    t_full();
    t_sq_empty();
    t_sq_walk();
    t_sq_head();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule